// File: doc/BRIEF.md
# Subsystem Message Block Transfer Engine

This block moves data words between a subsystem-side FIFO pair and a message RAM. The RAM holds two independent sections, one for transmit and one for receive. Each section holds 32 message blocks of 32 words. The subsystem first loads a 7-bit operation register with three fields: a block number (subaddress), a section select and a transfer direction. It then pulses `execute`.

In the input direction, every word queued in the input FIFO at the moment of the execute is written into the chosen block. Writing starts at word offset 0. In the output direction, all 32 words of the chosen block are copied into the output FIFO in offset order.

Requests that cannot complete are refused, with an error pulse and no data movement:
- an input request while the input FIFO is empty;
- an output request while the output FIFO has fewer than 32 free places.

While a transfer runs, `busy` is high and further execute pulses are ignored. A one-cycle `done` pulse marks successful completion.

Top module: `mbx_engine`

## Requirements
- R1: Operation register layout: bits 4..0 are the subaddress (bit 0 least significant), bit 5 is the section select (1 = transmit, 0 = receive), and bit 6 is the direction (1 = input FIFO to RAM, 0 = RAM to output FIFO). A write on `opWrEn` takes effect from the next cycle. The RAM word address is {section, subaddress, offset}.
- R2: An accepted input execute moves exactly the words held in the input FIFO in the execute cycle (1 to 32), in FIFO order, to offsets 0, 1, 2, … of the selected block. Words pushed after the execute cycle stay queued.
- R3: An accepted output execute appends the 32 words of the selected block to the output FIFO, offset 0 first.
- R4: The two sections are independent: writing a block in one section leaves the block with the same subaddress in the other section unchanged.
- R5: Subaddresses 0 and 31 are ordinary targets for both directions.
- R6: An input execute while the input FIFO is empty raises `error` for one cycle, does not raise `busy`, and changes no RAM word.
- R7: An output execute while the output FIFO holds more than 32 words raises `error` for one cycle, does not raise `busy`, and pushes no word.
- R8: After an accepted execute, `busy` is high for exactly N cycles, where N is the word count, starting in the cycle after the execute. One word moves per busy cycle.
- R9: An execute pulse while `busy` is high has no effect: no error, no restart, and no change to the running transfer.
- R10: `done` is high for exactly one cycle, the cycle right after `busy` falls. `done` and `error` are never high together.
- R11: The input FIFO holds 32 words and the output FIFO holds 64 words. A push into a full FIFO and a pop from an empty FIFO are ignored. `outWord` shows the oldest word of the output FIFO. `inCount` and `outCount` give the current fill levels.
- R12: After reset, `busy`, `done` and `error` are low and both FIFOs are empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| opWrEn | input | 1 | Load the operation register |
| opWrData | input | 7 | Operation value: {direction, section, subaddress} |
| execute | input | 1 | Start the transfer described by the operation register |
| inPush | input | 1 | Push `inWord` into the input FIFO |
| inWord | input | 16 | Input FIFO write data |
| inFull | output | 1 | Input FIFO full |
| inCount | output | 6 | Input FIFO fill level |
| outPop | input | 1 | Pop the output FIFO |
| outWord | output | 16 | Oldest output FIFO word |
| outEmpty | output | 1 | Output FIFO empty |
| outCount | output | 7 | Output FIFO fill level |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle pulse: transfer completed |
| error | output | 1 | One-cycle pulse: execute refused |

## Verification
The assertions assume that `execute` is a single-cycle pulse. They also assume that the operation register is not rewritten in the same cycle as an execute; otherwise the field the rejection checks read would be ambiguous. The bench always writes the operation register at least one cycle before it pulses `execute`. The bench does push input words while an input transfer runs, so that the latched word count is exercised. Execute pulses that arrive during `busy` are sent deliberately, always as isolated pulses.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

  // Strobes the control sequencer issues to the datapath each cycle
  typedef struct packed {
    logic inPop;    // retire the head of the input FIFO
    logic ramWr;    // write the input FIFO head into the RAM
    logic outPush;  // append the addressed RAM word to the output FIFO
  } mbxStrobe_t;

endpackage

// File: rtl/mbx_fifo.sv
module mbx_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 32
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       push,
  input  logic                       pop,
  input  logic [W-1:0]               din,
  output logic [W-1:0]               dout,
  output logic [$clog2(DEPTH+1)-1:0] count
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH+1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wrPtr, rdPtr;
  logic          doPush, doPop;

  assign doPush = push && (count != CW'(DEPTH));
  assign doPop  = pop && (count != '0);
  assign dout   = mem[rdPtr];

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= din;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (doPush) wrPtr <= (wrPtr == PW'(DEPTH-1)) ? '0 : wrPtr + 1'b1;
      if (doPop)  rdPtr <= (rdPtr == PW'(DEPTH-1)) ? '0 : rdPtr + 1'b1;
      case ({doPush, doPop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/mbx_datapath.sv
module mbx_datapath
  import mbx_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int RAM_AW    = 11,
  parameter int IN_DEPTH  = 32,
  parameter int OUT_DEPTH = 64,
  localparam int IN_CW    = $clog2(IN_DEPTH+1),
  localparam int OUT_CW   = $clog2(OUT_DEPTH+1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  mbxStrobe_t        strobe,
  input  logic [RAM_AW-1:0] ramAddr,
  input  logic              inPush,
  input  logic [DATA_W-1:0] inWord,
  input  logic              outPop,
  output logic [DATA_W-1:0] outWord,
  output logic [IN_CW-1:0]  inCount,
  output logic [OUT_CW-1:0] outCount,
  output logic              inFull,
  output logic              outEmpty
);
  localparam int RAM_WORDS = 1 << RAM_AW;

  logic [DATA_W-1:0] ram [RAM_WORDS];
  logic [DATA_W-1:0] inHead;
  logic [DATA_W-1:0] ramRd;

  mbx_fifo #(.W(DATA_W), .DEPTH(IN_DEPTH)) inFifo_i (
    .clk(clk), .rstN(rstN),
    .push(inPush), .pop(strobe.inPop),
    .din(inWord), .dout(inHead), .count(inCount)
  );

  assign ramRd = ram[ramAddr];

  always_ff @(posedge clk) begin
    if (strobe.ramWr) ram[ramAddr] <= inHead;
  end

  mbx_fifo #(.W(DATA_W), .DEPTH(OUT_DEPTH)) outFifo_i (
    .clk(clk), .rstN(rstN),
    .push(strobe.outPush), .pop(outPop),
    .din(ramRd), .dout(outWord), .count(outCount)
  );

  assign inFull   = (inCount == IN_CW'(IN_DEPTH));
  assign outEmpty = (outCount == '0);
endmodule

// File: rtl/mbx_ctrl.sv
module mbx_ctrl
  import mbx_pkg::*;
#(
  parameter int SA_W      = 5,
  parameter int OFF_W     = 5,
  parameter int OUT_DEPTH = 64,
  localparam int OP_W     = SA_W + 2,
  localparam int BLK      = 1 << OFF_W,
  localparam int RW       = OFF_W + 1,
  localparam int IN_CW    = $clog2(BLK+1),
  localparam int OUT_CW   = $clog2(OUT_DEPTH+1),
  localparam int RAM_AW   = 1 + SA_W + OFF_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              opWrEn,
  input  logic [OP_W-1:0]   opWrData,
  input  logic              execute,
  input  logic [IN_CW-1:0]  inCount,
  input  logic [OUT_CW-1:0] outCount,
  output mbxStrobe_t        strobe,
  output logic [RAM_AW-1:0] ramAddr,
  output logic [OP_W-1:0]   opCur,
  output logic              busy,
  output logic              done,
  output logic              error
);
  logic [SA_W-1:0]   actSa;
  logic              actTr, actDirIn;
  logic [OFF_W-1:0]  offset;
  logic [RW-1:0]     remain;
  logic [OUT_CW-1:0] outFree;
  logic              start, reject, accept, opDirIn;

  assign opDirIn = opCur[SA_W+1];
  assign outFree = OUT_CW'(OUT_DEPTH) - outCount;
  assign start   = execute && !busy;
  assign reject  = start && (opDirIn ? (inCount == '0) : (outFree < OUT_CW'(BLK)));
  assign accept  = start && !reject;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) opCur <= '0;
    else if (opWrEn) opCur <= opWrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy     <= 1'b0;
      done     <= 1'b0;
      error    <= 1'b0;
      actSa    <= '0;
      actTr    <= 1'b0;
      actDirIn <= 1'b0;
      offset   <= '0;
      remain   <= '0;
    end else begin
      done  <= 1'b0;
      error <= reject;
      if (accept) begin
        busy     <= 1'b1;
        actSa    <= opCur[SA_W-1:0];
        actTr    <= opCur[SA_W];
        actDirIn <= opDirIn;
        offset   <= '0;
        remain   <= opDirIn ? RW'(inCount) : RW'(BLK);
      end else if (busy) begin
        offset <= offset + 1'b1;
        remain <= remain - 1'b1;
        if (remain == RW'(1)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  always_comb begin
    strobe.inPop   = busy && actDirIn;
    strobe.ramWr   = busy && actDirIn;
    strobe.outPush = busy && !actDirIn;
  end

  assign ramAddr = {actTr, actSa, offset};
endmodule

// File: rtl/mbx_engine.sv
module mbx_engine
  import mbx_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int SA_W      = 5,
  parameter int OFF_W     = 5,
  parameter int OUT_DEPTH = 64,
  localparam int OP_W     = SA_W + 2,
  localparam int BLK      = 1 << OFF_W,
  localparam int IN_CW    = $clog2(BLK+1),
  localparam int OUT_CW   = $clog2(OUT_DEPTH+1),
  localparam int RAM_AW   = 1 + SA_W + OFF_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              opWrEn,
  input  logic [OP_W-1:0]   opWrData,
  input  logic              execute,
  input  logic              inPush,
  input  logic [DATA_W-1:0] inWord,
  output logic              inFull,
  output logic [IN_CW-1:0]  inCount,
  input  logic              outPop,
  output logic [DATA_W-1:0] outWord,
  output logic              outEmpty,
  output logic [OUT_CW-1:0] outCount,
  output logic              busy,
  output logic              done,
  output logic              error
);
  mbxStrobe_t        strobe;
  logic [RAM_AW-1:0] ramAddr;
  logic [OP_W-1:0]   opCur;

  mbx_ctrl #(.SA_W(SA_W), .OFF_W(OFF_W), .OUT_DEPTH(OUT_DEPTH)) ctrl_i (
    .clk(clk), .rstN(rstN),
    .opWrEn(opWrEn), .opWrData(opWrData), .execute(execute),
    .inCount(inCount), .outCount(outCount),
    .strobe(strobe), .ramAddr(ramAddr), .opCur(opCur),
    .busy(busy), .done(done), .error(error)
  );

  mbx_datapath #(.DATA_W(DATA_W), .RAM_AW(RAM_AW), .IN_DEPTH(BLK),
                 .OUT_DEPTH(OUT_DEPTH)) dp_i (
    .clk(clk), .rstN(rstN),
    .strobe(strobe), .ramAddr(ramAddr),
    .inPush(inPush), .inWord(inWord), .outPop(outPop),
    .outWord(outWord), .inCount(inCount), .outCount(outCount),
    .inFull(inFull), .outEmpty(outEmpty)
  );
endmodule

// File: rtl/mbx_engine_chk.sv
module mbx_engine_chk #(
  parameter int SA_W      = 5,
  parameter int OFF_W     = 5,
  parameter int OUT_DEPTH = 64,
  localparam int BLK      = 1 << OFF_W,
  localparam int IN_CW    = $clog2(BLK+1),
  localparam int OUT_CW   = $clog2(OUT_DEPTH+1)
) (
  input logic              clk,
  input logic              rstN,
  input logic              execute,
  input logic              opDirIn,
  input logic [IN_CW-1:0]  inCount,
  input logic [OUT_CW-1:0] outCount,
  input logic              busy,
  input logic              done,
  input logic              error
);
  a_r10_done_idle: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

  a_r10_done_single: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  a_r10_no_overlap: assert property (@(posedge clk) disable iff (!rstN)
    !(done && error));

  a_r8_fall_done: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> done);

  a_r6_empty_reject: assert property (@(posedge clk) disable iff (!rstN)
    (execute && !busy && opDirIn && inCount == '0) |=> (error && !busy));

  a_r7_room_reject: assert property (@(posedge clk) disable iff (!rstN)
    (execute && !busy && !opDirIn && outCount > OUT_CW'(OUT_DEPTH - BLK))
      |=> (error && !busy));

  a_r9_busy_no_error: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> !error);

  a_r11_out_bound: assert property (@(posedge clk) disable iff (!rstN)
    outCount <= OUT_CW'(OUT_DEPTH));

  a_r11_in_bound: assert property (@(posedge clk) disable iff (!rstN)
    inCount <= IN_CW'(BLK));
endmodule

bind mbx_engine mbx_engine_chk #(.SA_W(SA_W), .OFF_W(OFF_W), .OUT_DEPTH(OUT_DEPTH)) chk_i (
  .clk(clk), .rstN(rstN), .execute(execute), .opDirIn(opCur[SA_W+1]),
  .inCount(inCount), .outCount(outCount),
  .busy(busy), .done(done), .error(error)
);

// File: tb/mbx_engine_tb_top.sv
module mbx_engine_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        opWrEn = 1'b0;
  logic [6:0]  opWrData = '0;
  logic        execute = 1'b0;
  logic        inPush = 1'b0;
  logic [15:0] inWord = '0;
  logic        outPop = 1'b0;
  logic        inFull, outEmpty, busy, done, error;
  logic [5:0]  inCount;
  logic [6:0]  outCount;
  logic [15:0] outWord;

  int checks = 0;
  int fails = 0;
  string phase = "reset";

  always #2 clk = ~clk;

  mbx_engine dut_i (
    .clk(clk), .rstN(rstN), .opWrEn(opWrEn), .opWrData(opWrData),
    .execute(execute), .inPush(inPush), .inWord(inWord),
    .inFull(inFull), .inCount(inCount), .outPop(outPop),
    .outWord(outWord), .outEmpty(outEmpty), .outCount(outCount),
    .busy(busy), .done(done), .error(error)
  );

  // ---------------- behavioural reference model ----------------
  int inQ[$];
  int outQ[$];
  int mram[int];
  bit mBusy, mDone, mErr, mDirIn;
  int mTr, mSa, mOff, mRem;
  logic [6:0] mOp;

  always @(posedge clk) begin
    if (!rstN) begin
      inQ.delete(); outQ.delete();
      mBusy = 0; mDone = 0; mErr = 0; mOp = '0;
    end else begin
      int preIn, preOut, addr;
      bit wasBusy;
      preIn = inQ.size(); preOut = outQ.size(); wasBusy = mBusy;
      mDone = 0; mErr = 0;
      if (outPop && preOut > 0) void'(outQ.pop_front());
      if (inPush && preIn < 32) inQ.push_back(int'(inWord));
      if (wasBusy) begin
        addr = (mTr << 10) | (mSa << 5) | mOff;
        if (mDirIn) mram[addr] = inQ.pop_front();
        else outQ.push_back(mram.exists(addr) ? mram[addr] : -1);
        mOff++; mRem--;
        if (mRem == 0) begin mBusy = 0; mDone = 1; end
      end
      if (!wasBusy && execute) begin
        if (mOp[6] ? (preIn == 0) : ((64 - preOut) < 32)) mErr = 1;
        else begin
          mBusy = 1; mDirIn = mOp[6]; mTr = int'(mOp[5]); mSa = int'(mOp[4:0]);
          mOff = 0; mRem = mOp[6] ? preIn : 32;
        end
      end
      if (opWrEn) mOp = opWrData;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s [%s] actual=%0d expected=%0d", req, phase, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rstN) begin
      check("R8 busy", int'(busy), int'(mBusy));
      check("R10 done", int'(done), int'(mDone));
      check("R6/R7 error", int'(error), int'(mErr));
      check("R2 inCount", int'(inCount), inQ.size());
      check("R11 outCount", int'(outCount), outQ.size());
      check("R11 inFull", int'(inFull), int'(inQ.size() == 32));
      check("R11 outEmpty", int'(outEmpty), int'(outQ.size() == 0));
      if (outQ.size() > 0 && outQ[0] != -1)
        check("R3 outWord", int'(outWord), outQ[0]);
    end
  end

  // ---------------- stimulus tasks (called just after a negedge) ----------------
  task automatic setOp(input bit dirIn, input bit tr, input int sa);
    opWrEn = 1; opWrData = {dirIn, tr, 5'(sa)};
    @(negedge clk); opWrEn = 0;
  endtask

  task automatic pulseExec();
    execute = 1; @(negedge clk); execute = 0;
  endtask

  task automatic pushWords(input int n, input int base);
    for (int i = 0; i < n; i++) begin
      inPush = 1; inWord = 16'(base + i); @(negedge clk);
    end
    inPush = 0;
  endtask

  task automatic waitIdle();
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic drain();
    while (!outEmpty) begin outPop = 1; @(negedge clk); end
    outPop = 0; @(negedge clk);
  endtask

  task automatic fillBlock(input bit tr, input int sa, input int base);
    pushWords(32, base);
    setOp(1'b1, tr, sa);
    pulseExec();
    waitIdle();
  endtask

  task automatic readBlock(input bit tr, input int sa);
    setOp(1'b0, tr, sa);
    pulseExec();
    waitIdle();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired [%s] actual=running expected=finished", phase);
    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R12: reset state
    check("R12 busy", int'(busy), 0);
    check("R12 done", int'(done), 0);
    check("R12 error", int'(error), 0);
    check("R12 inCount", int'(inCount), 0);
    check("R12 outCount", int'(outCount), 0);
    rstN = 1;
    @(negedge clk);

    // R1/R4/R5: full blocks in both sections, edge subaddresses included
    phase = "R5 sa0 sa31 and R4 sections";
    fillBlock(1'b1, 0, 16'h1000);
    fillBlock(1'b0, 31, 16'h2000);
    fillBlock(1'b0, 3, 16'h3000);
    fillBlock(1'b1, 3, 16'h4000);

    // R2: partial input overwrites offsets 0..4 only
    phase = "R2 partial input";
    pushWords(5, 16'h5000);
    setOp(1'b1, 1'b0, 3);
    pulseExec();
    waitIdle();

    phase = "R1 R3 R4 readback";
    readBlock(1'b0, 3);
    drain();
    readBlock(1'b1, 3);
    drain();

    // R7: two outputs fill 64 places, the third is refused
    phase = "R7 output room";
    readBlock(1'b1, 0);
    readBlock(1'b0, 31);
    readBlock(1'b0, 3);
    check("R7 outCount after refusal", int'(outCount), 64);
    drain();

    // R6: empty input FIFO refusal, block left intact
    phase = "R6 empty input";
    setOp(1'b1, 1'b1, 0);
    pulseExec();
    @(negedge clk);
    readBlock(1'b1, 0);
    drain();

    // R9: execute during an output transfer is ignored
    phase = "R9 execute while busy";
    pushWords(2, 16'h6000);
    setOp(1'b0, 1'b0, 31);
    pulseExec();
    repeat (3) @(negedge clk);
    setOp(1'b1, 1'b1, 7);
    pulseExec();
    waitIdle();
    check("R9 input words untouched", int'(inCount), 2);
    drain();

    // R2: pushes during an input transfer stay queued
    phase = "R2 push during transfer";
    pushWords(2, 16'h6100);
    setOp(1'b1, 1'b0, 31);
    pulseExec();
    pushWords(3, 16'h7000);
    waitIdle();
    check("R2 late words kept", int'(inCount), 3);
    setOp(1'b1, 1'b1, 31);
    pulseExec();
    waitIdle();
    readBlock(1'b0, 31);
    drain();

    // R11: push into full input FIFO and pop from empty output FIFO
    phase = "R11 fifo bounds";
    pushWords(33, 16'h8000);
    check("R11 full level", int'(inCount), 32);
    outPop = 1; @(negedge clk); outPop = 0;
    check("R11 empty pop", int'(outCount), 0);
    setOp(1'b1, 1'b0, 9);
    pulseExec();
    waitIdle();
    readBlock(1'b0, 9);
    drain();

    phase = "end";
    repeat (2) @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule